// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the bit-level layer of an I2C master. A controller gives it one command at a time: start condition, stop condition, byte write, byte read with a chosen acknowledge level, or bus recovery. The block then produces the SCL and SDA waveforms for that command as open-drain output enables and samples the SDA line. A write returns the acknowledge level that the addressed device drove. A read returns the assembled byte.

Every phase of every waveform lasts a whole number of delay units. A delay unit is `UNIT_CYC` clock cycles, which is a quarter of a nominal SCL period. The engine never drives a line high: a logic one is always a released enable. The SDA input goes through a synchronizer before it is sampled. The controller sees a `busy` flag, and then a one-cycle `done` pulse when the command ends. Transaction framing (addresses, retries, byte counts) is left to the controller above this block.

Top module: `i2c_bitseq_master`

## Requirements
- R1: After synchronous reset, `scl_oe`, `sda_oe`, `busy` and `done` are all 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1, `busy` is 0 and `cmd_op` is legal. `busy` is 1 from that edge until `done` pulses high for exactly one cycle. That pulse comes exactly N×`UNIT_CYC` cycles after the accepting edge, with N = 4 for start, 4 for stop, 37 for write, 29 for read and 40 for recovery.
- R3: Start (`cmd_op`=1) keeps the bus as it is for one unit, then releases SDA for one unit, then releases SCL for one unit, then pulls SDA low for one unit.
- R4: Stop (`cmd_op`=2) pulls SCL low for one unit, then pulls SDA low for one unit, then releases SCL for one unit, then releases SDA for one unit.
- R5: Write (`cmd_op`=3) sends `cmd_wdata` MSB first. For each bit it gives one unit of SCL low with the old SDA, then one unit of SCL low with the bit on SDA, then two units of SCL high. The acknowledge phase follows: SCL low for one unit, SDA released for one unit, SCL high for two units, then SCL low for one unit. SDA is sampled at the end of the SCL-high part, and that level is returned on `ack_bit` unchanged (0 = acknowledged, 1 = not acknowledged).
- R6: Read (`cmd_op`=4) releases SDA and takes in 8 bits MSB first. For each bit it gives SCL low for one unit, then SCL high for two units. SDA is sampled after the first of the two high units. The byte is on `rdata` when `done` pulses.
- R7: After the 8 read bits, the engine drives `cmd_ack_lvl` on SDA: 0 pulls SDA low, 1 releases it. This takes SCL low for one unit (previous SDA), SCL low for one unit with the level applied, SCL high for two units, then SCL low for one unit.
- R8: Recovery (`cmd_op`=5) releases SDA and gives 9 SCL pulses, each two units low and then two units high. A full stop sequence as in R4 follows.
- R9: Both lines are open drain. An enable of 1 pulls the line low and an enable of 0 releases it, so no output ever drives a high level. The SDA input is sampled only after a two-stage synchronizer.
- R10: While `busy` is 1, a new `cmd_valid` has no effect on the waveform or its length. Codes 0, 6 and 7 are never accepted: `busy` stays 0 and both enables keep their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code: 1 start, 2 stop, 3 write, 4 read, 5 recovery |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_ack_lvl | input | 1 | Acknowledge level driven after a read (0 continue, 1 end) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rdata | output | 8 | Byte assembled by the last read |
| ack_bit | output | 1 | Acknowledge level sampled by the last write |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Each waveform phase starts on the clock edge that ends the previous phase. The bench therefore samples every delay unit at its middle, on a falling clock edge `UNIT_CYC/2` cycles into the unit, and counts units from the edge that accepted the command. `done` is due exactly N×`UNIT_CYC` cycles after that accepting edge, and the bench checks the count to the exact cycle. `ack_bit` and `rdata` are due on the `done` cycle, and the monitor compares them there against the entry the driver pushed into the scoreboard. The bench model of the addressed device changes its SDA level at the start of each unit. This keeps the level steady for more than the synchronizer delay before the engine samples it.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int BYTE_BITS      = 8;
  localparam int RECOVER_PULSES = 9;
  localparam int IDX_W          = $clog2(RECOVER_PULSES + 1);
  localparam int BIT_W          = $clog2(BYTE_BITS);

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_RECOVER = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SD_KEEP = 2'd0,
    SD_REL  = 2'd1,
    SD_LOW  = 2'd2,
    SD_VAL  = 2'd3
  } sda_act_e;

  // One waveform step: the level it applies and how it ends.
  typedef struct packed {
    logic     scl_set;
    logic     scl_lo;
    sda_act_e sda;
    logic     two;
    logic     sample;
    logic     bit_end;
    logic     last;
  } step_t;

  localparam step_t STEP_IDLE = '{scl_set: 1'b0, scl_lo: 1'b0, sda: SD_KEEP,
                                  two: 1'b0, sample: 1'b0, bit_end: 1'b0, last: 1'b0};

  function automatic logic op_legal(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic step_t stop_step(input logic [1:0] sub);
    step_t st;
    st = STEP_IDLE;
    case (sub)
      2'd0: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; end
      2'd1: st.sda = SD_LOW;
      2'd2: st.scl_set = 1'b1;
      default: begin st.sda = SD_REL; st.last = 1'b1; end
    endcase
    return st;
  endfunction

  function automatic step_t step_decode(input op_e op, input logic [IDX_W-1:0] bidx,
                                        input logic [1:0] sub);
    step_t st;
    logic  data_ph;
    logic  rec_ph;
    st      = STEP_IDLE;
    data_ph = (bidx < IDX_W'(BYTE_BITS));
    rec_ph  = (bidx < IDX_W'(RECOVER_PULSES));
    case (op)
      OP_START: begin
        case (sub)
          2'd0: st.sda = SD_KEEP;
          2'd1: st.sda = SD_REL;
          2'd2: st.scl_set = 1'b1;
          default: begin st.sda = SD_LOW; st.last = 1'b1; end
        endcase
      end
      OP_STOP: st = stop_step(sub);
      OP_WRITE: begin
        if (data_ph) begin
          case (sub)
            2'd0: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; end
            2'd1: st.sda = SD_VAL;
            default: begin st.scl_set = 1'b1; st.two = 1'b1; st.bit_end = 1'b1; end
          endcase
        end else begin
          case (sub)
            2'd0: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; end
            2'd1: st.sda = SD_REL;
            2'd2: begin st.scl_set = 1'b1; st.two = 1'b1; st.sample = 1'b1; end
            default: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; st.last = 1'b1; end
          endcase
        end
      end
      OP_READ: begin
        if (data_ph) begin
          case (sub)
            2'd0: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; st.sda = SD_REL; end
            2'd1: begin st.scl_set = 1'b1; st.sample = 1'b1; end
            default: st.bit_end = 1'b1;
          endcase
        end else begin
          case (sub)
            2'd0: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; end
            2'd1: st.sda = SD_VAL;
            2'd2: begin st.scl_set = 1'b1; st.two = 1'b1; end
            default: begin st.scl_set = 1'b1; st.scl_lo = 1'b1; st.last = 1'b1; end
          endcase
        end
      end
      OP_RECOVER: begin
        if (rec_ph) begin
          if (sub == 2'd0) begin
            st.scl_set = 1'b1; st.scl_lo = 1'b1; st.sda = SD_REL; st.two = 1'b1;
          end else begin
            st.scl_set = 1'b1; st.two = 1'b1; st.bit_end = 1'b1;
          end
        end else begin
          st = stop_step(sub);
        end
      end
      default: st.last = 1'b1;
    endcase
    return st;
  endfunction

  // Returns {scl_lo, sda_lo} after applying a step to the current bus levels.
  function automatic logic [1:0] bus_next(input step_t st, input logic scl_lo,
                                          input logic sda_lo, input logic val);
    logic s;
    logic d;
    s = st.scl_set ? st.scl_lo : scl_lo;
    case (st.sda)
      SD_KEEP: d = sda_lo;
      SD_REL:  d = 1'b0;
      SD_LOW:  d = 1'b1;
      default: d = ~val;
    endcase
    return {s, d};
  endfunction

endpackage

// File: rtl/i2cb_tick_gen.sv
module i2cb_tick_gen #(
  parameter int UNIT_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R2: a delay unit never runs past UNIT_CYC cycles
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);

endmodule

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= 1'b1;
        else     r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[STAGES-2:0], d};
      end
      assign q = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BYTE_BITS-1:0] cmd_wdata,
  input  logic                 cmd_ack_lvl,
  input  logic                 tick,
  input  logic                 sda_s,
  output logic                 tick_clr,
  output logic                 busy,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rdata,
  output logic                 ack_bit,
  output logic                 scl_oe,
  output logic                 sda_oe
);
  op_e                  op_q;
  logic [IDX_W-1:0]     bidx_q;
  logic [1:0]           sub_q;
  logic                 unit2_q;
  logic                 busy_q;
  logic                 done_q;
  logic [BYTE_BITS-1:0] wdata_q;
  logic [BYTE_BITS-1:0] rx_q;
  logic                 ack_lvl_q;
  logic                 ack_q;
  logic                 scl_oe_q;
  logic                 sda_oe_q;

  op_e              op_in;
  logic             accept;
  step_t            st_cur;
  step_t            st_nxt;
  step_t            st_first;
  logic [IDX_W-1:0] nbidx;
  logic [1:0]       nsub;
  logic             nval;

  assign op_in  = op_e'(cmd_op);
  assign accept = cmd_valid && !busy_q && op_legal(cmd_op);

  always_comb begin
    st_cur = step_decode(op_q, bidx_q, sub_q);
    if (st_cur.bit_end) begin
      nbidx = bidx_q + {{(IDX_W-1){1'b0}}, 1'b1};
      nsub  = 2'd0;
    end else begin
      nbidx = bidx_q;
      nsub  = sub_q + 2'd1;
    end
    st_nxt   = step_decode(op_q, nbidx, nsub);
    nval     = (op_q == OP_WRITE) ? wdata_q[~nbidx[BIT_W-1:0]] : ack_lvl_q;
    st_first = step_decode(op_in, '0, 2'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_NONE;
      bidx_q    <= '0;
      sub_q     <= 2'd0;
      unit2_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      wdata_q   <= '0;
      rx_q      <= '0;
      ack_lvl_q <= 1'b1;
      ack_q     <= 1'b1;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        op_q      <= op_in;
        bidx_q    <= '0;
        sub_q     <= 2'd0;
        wdata_q   <= cmd_wdata;
        ack_lvl_q <= cmd_ack_lvl;
        unit2_q   <= st_first.two;
        {scl_oe_q, sda_oe_q} <= bus_next(st_first, scl_oe_q, sda_oe_q, cmd_wdata[BYTE_BITS-1]);
      end else if (busy_q && tick) begin
        if (unit2_q) begin
          unit2_q <= 1'b0;
        end else begin
          if (st_cur.sample) begin
            if (op_q == OP_WRITE) ack_q <= sda_s;
            else                  rx_q  <= {rx_q[BYTE_BITS-2:0], sda_s};
          end
          if (st_cur.last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bidx_q  <= nbidx;
            sub_q   <= nsub;
            unit2_q <= st_nxt.two;
            {scl_oe_q, sda_oe_q} <= bus_next(st_nxt, scl_oe_q, sda_oe_q, nval);
          end
        end
      end
    end
  end

  assign tick_clr = accept;
  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = rx_q;
  assign ack_bit  = ack_q;
  assign scl_oe   = scl_oe_q;
  assign sda_oe   = sda_oe_q;

  // R2: done only closes a command that was running
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));
  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R5: inside a byte transfer SDA moves only while SCL is held low
  p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && (op_q == OP_WRITE || op_q == OP_READ) && !$stable(sda_oe_q))
      |-> (scl_oe_q && $past(scl_oe_q)));
  // R10: the running command cannot be replaced
  p_op_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(op_q));
  // R10: with no command running the bus levels hold
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> ($stable(scl_oe_q) && $stable(sda_oe_q)));

endmodule

// File: rtl/i2c_bitseq_master.sv
module i2c_bitseq_master #(
  parameter int UNIT_CYC    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_ack_lvl,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack_bit,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic tick;
  logic tick_clr;
  logic sda_s;

  i2cb_tick_gen #(.UNIT_CYC(UNIT_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (tick_clr),
    .tick(tick)
  );

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (sda_in),
    .q  (sda_s)
  );

  i2cb_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_ack_lvl(cmd_ack_lvl),
    .tick       (tick),
    .sda_s      (sda_s),
    .tick_clr   (tick_clr),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata),
    .ack_bit    (ack_bit),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );
endmodule

// File: tb/i2c_bitseq_master_tb_top.sv
module i2c_bitseq_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_ack_lvl = 1'b1;
  logic       busy, done, ack_bit, scl_oe, sda_oe, sda_in;
  logic [7:0] rdata;
  logic       slave_lo = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  // expected units: {scl_lo, sda_lo from master, device pulls SDA low}
  logic [2:0] exp_u[$];
  int         sb_units[$];
  logic [1:0] sb_ack[$];
  logic [8:0] sb_rd[$];
  string      sb_tag[$];
  logic       b_scl = 1'b0;
  logic       b_sda = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = ~(sda_oe | slave_lo);

  i2c_bitseq_master #(.UNIT_CYC(UNIT)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl), .busy(busy), .done(done),
    .rdata(rdata), .ack_bit(ack_bit), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add(input logic s, input logic d, input logic v);
    exp_u.push_back({s, d, v});
    b_scl = s;
    b_sda = d;
  endtask

  task automatic build_start();
    add(b_scl, b_sda, 1'b0); add(b_scl, 1'b0, 1'b0); add(1'b0, 1'b0, 1'b0); add(1'b0, 1'b1, 1'b0);
  endtask

  task automatic build_stop();
    add(1'b1, b_sda, 1'b0); add(1'b1, 1'b1, 1'b0); add(1'b0, 1'b1, 1'b0); add(1'b0, 1'b0, 1'b0);
  endtask

  task automatic build_write(input logic [7:0] d, input logic dev_ack);
    for (int i = 7; i >= 0; i--) begin
      add(1'b1, b_sda, 1'b0); add(1'b1, ~d[i], 1'b0); add(1'b0, ~d[i], 1'b0); add(1'b0, ~d[i], 1'b0);
    end
    add(1'b1, b_sda, dev_ack); add(1'b1, 1'b0, dev_ack); add(1'b0, 1'b0, dev_ack);
    add(1'b0, 1'b0, dev_ack); add(1'b1, 1'b0, dev_ack);
  endtask

  task automatic build_read(input logic [7:0] d, input logic lvl);
    for (int i = 7; i >= 0; i--) begin
      add(1'b1, 1'b0, ~d[i]); add(1'b0, 1'b0, ~d[i]); add(1'b0, 1'b0, ~d[i]);
    end
    add(1'b1, b_sda, 1'b0); add(1'b1, ~lvl, 1'b0); add(1'b0, ~lvl, 1'b0);
    add(1'b0, ~lvl, 1'b0); add(1'b1, ~lvl, 1'b0);
  endtask

  task automatic build_recover();
    for (int p = 0; p < 9; p++) begin
      add(1'b1, 1'b0, 1'b0); add(1'b1, 1'b0, 1'b0); add(1'b0, 1'b0, 1'b0); add(1'b0, 1'b0, 1'b0);
    end
    build_stop();
  endtask

  // driver: push the scoreboard entry, issue, wait for completion
  task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic lvl,
                       input int units, input logic [1:0] ack_e, input logic [8:0] rd_e,
                       input string tag, input bit poke);
    sb_units.push_back(units);
    sb_ack.push_back(ack_e);
    sb_rd.push_back(rd_e);
    sb_tag.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = lvl;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    @(negedge clk iff done);
    @(negedge clk);
    exp_u.delete();
  endtask

  // monitor: per-unit waveform compare, device model, result compare at done
  int         k = -1;
  int         wf_err = 0;
  logic [1:0] wf_act, wf_exp;
  logic       prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      k = -1;
      prev_done = 1'b0;
    end else begin
      if (prev_done) check("R2 done longer than one cycle", {31'b0, done}, 32'd0);
      prev_done = done;
      if (busy && k < 0) begin
        k = 0;
        wf_err = 0;
      end else if (k >= 0) begin
        k++;
      end
      if (busy && k >= 0) begin
        if (k % UNIT == 0) slave_lo = (k / UNIT < exp_u.size()) ? exp_u[k / UNIT][0] : 1'b0;
        if (k % UNIT == UNIT / 2 && k / UNIT < exp_u.size()) begin
          if ({scl_oe, sda_oe} !== exp_u[k / UNIT][2:1]) begin
            if (wf_err == 0) begin
              wf_act = {scl_oe, sda_oe};
              wf_exp = exp_u[k / UNIT][2:1];
            end
            wf_err++;
          end
        end
      end
      if (done && k >= 0 && sb_units.size() > 0) begin
        int       u_e;
        logic [1:0] a_e;
        logic [8:0] r_e;
        string    t;
        u_e = sb_units.pop_front();
        a_e = sb_ack.pop_front();
        r_e = sb_rd.pop_front();
        t   = sb_tag.pop_front();
        check({t, " R2 duration"}, k, u_e * UNIT);
        if (wf_err == 0) check({t, " R9 waveform"}, 32'd0, 32'd0);
        else check({t, " R9 waveform (first bad unit {scl_oe,sda_oe})"}, {30'b0, wf_act}, {30'b0, wf_exp});
        if (a_e[1]) check({t, " ack_bit"}, {31'b0, ack_bit}, {31'b0, a_e[0]});
        if (r_e[8]) check({t, " rdata"}, {24'b0, rdata}, {24'b0, r_e[7:0]});
        k = -1;
        slave_lo = 1'b0;
      end
    end
  end

  task automatic run_all();
    logic [1:0] snap;
    bit         seen_busy;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {28'b0, scl_oe, sda_oe, busy, done}, 32'd0);

    build_recover();
    issue(3'd5, 8'h00, 1'b1, 40, 2'b00, 9'h000, "R8 recovery", 1'b0);
    build_start();
    issue(3'd1, 8'h00, 1'b1, 4, 2'b00, 9'h000, "R3 start", 1'b0);
    build_write(8'hA5, 1'b1);
    issue(3'd3, 8'hA5, 1'b1, 37, 2'b10, 9'h000, "R5 write acked", 1'b0);
    build_write(8'h3C, 1'b0);
    issue(3'd3, 8'h3C, 1'b1, 37, 2'b11, 9'h000, "R5 write not acked", 1'b0);
    build_read(8'h96, 1'b0);
    issue(3'd4, 8'h00, 1'b0, 29, 2'b00, 9'h196, "R6 R7 read continue", 1'b0);
    build_read(8'h5A, 1'b1);
    issue(3'd4, 8'h00, 1'b1, 29, 2'b00, 9'h15A, "R6 R7 read end", 1'b0);
    build_stop();
    issue(3'd2, 8'h00, 1'b1, 4, 2'b00, 9'h000, "R4 stop", 1'b0);
    build_start();
    issue(3'd1, 8'h00, 1'b1, 4, 2'b00, 9'h000, "R3 start again", 1'b0);
    build_write(8'h01, 1'b1);
    issue(3'd3, 8'h01, 1'b1, 37, 2'b10, 9'h000, "R5 write low bits", 1'b0);
    build_recover();
    issue(3'd5, 8'h00, 1'b1, 40, 2'b00, 9'h000, "R10 R8 recovery with request while busy", 1'b1);

    // R10: undefined codes are not accepted and leave the bus as it is
    snap = {scl_oe, sda_oe};
    seen_busy = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3 * UNIT) begin
        @(negedge clk);
        if (busy || done) seen_busy = 1'b1;
      end
    end
    check("R10 undefined code accepted", {31'b0, seen_busy}, 32'd0);
    check("R10 bus changed by undefined code", {30'b0, scl_oe, sda_oe}, {30'b0, snap});

    build_start();
    issue(3'd1, 8'h00, 1'b1, 4, 2'b00, 9'h000, "R3 start after recovery", 1'b0);
    build_stop();
    issue(3'd2, 8'h00, 1'b1, 4, 2'b00, 9'h000, "R4 stop after start", 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule